// File: doc/BRIEF.md
# SCOM Bridge with Local Register Interception

This block sits between a 64-bit memory-mapped slave port and an internal SCOM register bus. Every accepted access carries a byte offset. A clear top offset bit selects the SCOM window, and the offset divided by eight gives a 32-bit register address. A small built-in table then decides how the access is handled. The chip identity register answers with a configured constant. A group of status, log, error, fault-isolation and mask registers reads as zero. Writes to the protected addresses are dropped. Every other address goes out on a downstream request port at byte address `register << 3`. The bridge waits for the single-cycle downstream response before it answers the master.

The memory-mapped side carries data most-significant byte first, and the downstream side uses native order, so the bridge swaps bytes in both directions. Each completed SCOM access ORs a done flag, plus a fail flag when the downstream port reports an error, into a completion status register. That register sits at offset `0x8_0000_0000` (top offset bit set). Software reads it there and clears its bits by writing ones.

Top module: `scom_bridge`

## Requirements
- R1: An access whose size is not 8 bytes, or whose offset bits [2:0] are not zero, is answered one cycle after acceptance with `mmio_rsp_err`=1 and zero data. It makes no downstream request and leaves both status flags unchanged.
- R2: In the SCOM window (offset bit 35 = 0) the register address is offset bits [34:3]. A forwarded access drives `dn_req_addr` = {register address, 3'b000} with `dn_req_write` equal to the master's write flag.
- R3: A read of register 0x000f000f returns the CHIP_ID parameter, and a write to it is dropped with no downstream request.
- R4: Reads of registers 0x00018002, 0x01010c00, 0x01010c03, 0x01020013, 0x01020014, 0x000f0033, 0x000f0034, 0x00090012, 0x00090013, 0x00090018, 0x02020007, 0x02020009, 0x0202000f, 0x02013f01 and 0x02013f05 return zero with no downstream request. Reads of any other address, including 0x01010c01, are forwarded.
- R5: Writes are dropped with no downstream request for the R4 set (minus 0x02013f01 and 0x02013f05), for 0x000f000f, and for 0x01010c01, 0x01010c02, 0x01010c04 and 0x01010c05.
- R6: Writes to 0x02013f01 and 0x02013f05 are forwarded downstream, while reads of those two addresses are answered locally with zero.
- R7: Byte lane i (bits 8i+7:8i) of the memory-mapped data maps to byte lane 7-i of the downstream data, in both directions. The chip identity is returned in the same swapped order. Write responses carry zero data.
- R8: `dn_req_valid` stays high with stable address, data and write flag until `dn_req_ready`. `mmio_req_ready` stays low from acceptance of a forwarded access until its response.
- R9: Every valid SCOM access, whether local, dropped or forwarded, sets the done flag (status bit 0).
- R10: A downstream response with `dn_rsp_err`=1 sets both the fail flag (status bit 1) and the done flag, and a failed read returns zero data.
- R11: Reading the status offset returns {62'b0, fail, done} in native bit order. A write there clears each flag whose write-data bit is one. Status accesses never set a flag, and the flags otherwise hold until cleared.
- R12: Local, dropped, status and rejected accesses answer with `mmio_rsp_valid` one cycle after acceptance. A forwarded access answers one cycle after `dn_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmio_req_valid | input | 1 | Master request valid |
| mmio_req_ready | output | 1 | Bridge can accept a request |
| mmio_req_write | input | 1 | 1 = write, 0 = read |
| mmio_req_addr | input | 36 | Byte offset; bit 35 selects the status register |
| mmio_req_size | input | 4 | Access size in bytes |
| mmio_req_wdata | input | 64 | Write data, big-endian |
| mmio_rsp_valid | output | 1 | One-cycle response strobe |
| mmio_rsp_err | output | 1 | Access rejected for size or alignment |
| mmio_rsp_rdata | output | 64 | Read data, big-endian |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_addr | output | 35 | Downstream byte address |
| dn_req_wdata | output | 64 | Downstream write data, native order |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_err | input | 1 | Downstream access failed |
| dn_rsp_rdata | input | 64 | Downstream read data, native order |

## Verification
Every response of the bridge is registered. A local, dropped, status or rejected access is therefore checked at the first falling edge after its accepting rising edge, and the bench also checks that this one-cycle latency holds. A forwarded access is checked at the first falling edge after the clock that captured `dn_rsp_valid`. The downstream model stalls `dn_req_ready` for one cycle and checks at the next falling edge that the request held steady. The absence of downstream traffic is judged two cycles after each local response, by which time any request would already have appeared.

// File: rtl/scom_bridge_pkg.sv
package scom_bridge_pkg;

  typedef enum logic [1:0] {
    ACT_FWD  = 2'd0,
    ACT_ZERO = 2'd1,
    ACT_ID   = 2'd2,
    ACT_DROP = 2'd3
  } scom_act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DREQ  = 2'd1,
    ST_DWAIT = 2'd2
  } scom_state_e;

  localparam logic [31:0] IDENT_REG = 32'h000f_000f;

  function automatic logic [63:0] lane_swap(input logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      r[8*i +: 8] = d[8*(7-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/scom_addr_filter.sv
module scom_addr_filter
  import scom_bridge_pkg::*;
#(
  parameter int RAW = 32
) (
  input  logic [RAW-1:0] reg_addr,
  input  logic           is_write,
  output scom_act_e      act
);

  logic [31:0] a32;
  logic        quiet_grp;
  logic        rd_only_grp;
  logic        wr_only_grp;

  generate
    if (RAW >= 32) begin : g_wide
      logic hi_zero;
      if (RAW > 32) begin : g_hi
        assign hi_zero = (reg_addr[RAW-1:32] == '0);
      end else begin : g_nohi
        assign hi_zero = 1'b1;
      end
      assign a32 = hi_zero ? reg_addr[31:0] : 32'hffff_ffff;
    end else begin : g_narrow
      assign a32 = {{(32-RAW){1'b0}}, reg_addr};
    end
  endgenerate

  always_comb begin
    quiet_grp = 1'b0;
    case (a32)
      32'h0001_8002, 32'h0101_0c00, 32'h0101_0c03,
      32'h0102_0013, 32'h0102_0014, 32'h000f_0033, 32'h000f_0034,
      32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
      32'h0202_0007, 32'h0202_0009, 32'h0202_000f: quiet_grp = 1'b1;
      default: quiet_grp = 1'b0;
    endcase
  end

  always_comb begin
    rd_only_grp = (a32 == 32'h0201_3f01) || (a32 == 32'h0201_3f05);
    wr_only_grp = (a32 == 32'h0101_0c01) || (a32 == 32'h0101_0c02) ||
                  (a32 == 32'h0101_0c04) || (a32 == 32'h0101_0c05);
  end

  always_comb begin
    act = ACT_FWD;
    if (a32 == IDENT_REG) begin
      act = is_write ? ACT_DROP : ACT_ID;
    end else if (is_write) begin
      if (quiet_grp || wr_only_grp) act = ACT_DROP;
    end else begin
      if (quiet_grp || rd_only_grp) act = ACT_ZERO;
    end
  end

endmodule

// File: rtl/scom_cpl_status.sv
module scom_cpl_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_done,
  input  logic       set_fail,
  input  logic       clr_en,
  input  logic [1:0] clr_mask,
  output logic       done,
  output logic       fail
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= (done & ~(clr_en & clr_mask[0])) | set_done;
      fail <= (fail & ~(clr_en & clr_mask[1])) | set_fail;
    end
  end

endmodule

// File: rtl/scom_bridge.sv
module scom_bridge
  import scom_bridge_pkg::*;
#(
  parameter int          RAW     = 32,
  parameter int          DW      = 64,
  parameter logic [63:0] CHIP_ID = 64'h0000_0120_d049_8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mmio_req_valid,
  output logic              mmio_req_ready,
  input  logic              mmio_req_write,
  input  logic [RAW+3:0]    mmio_req_addr,
  input  logic [3:0]        mmio_req_size,
  input  logic [DW-1:0]     mmio_req_wdata,
  output logic              mmio_rsp_valid,
  output logic              mmio_rsp_err,
  output logic [DW-1:0]     mmio_rsp_rdata,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [RAW+2:0]    dn_req_addr,
  output logic [DW-1:0]     dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic              dn_rsp_err,
  input  logic [DW-1:0]     dn_rsp_rdata
);

  localparam int MAW        = RAW + 4;
  localparam int WORD_BYTES = DW / 8;

  scom_state_e    state;
  scom_act_e      act;
  logic [RAW-1:0] reg_addr;
  logic           acc;
  logic           shape_ok;
  logic           in_status;
  logic           st_done;
  logic           st_fail;
  logic           set_done;
  logic           set_fail;
  logic           clr_en;
  logic           dn_fin;

  assign reg_addr       = mmio_req_addr[MAW-2:3];
  assign in_status      = mmio_req_addr[MAW-1];
  assign shape_ok       = (mmio_req_size == 4'(WORD_BYTES)) && (mmio_req_addr[2:0] == 3'b000);
  assign mmio_req_ready = (state == ST_IDLE);
  assign acc            = mmio_req_valid && mmio_req_ready;
  assign dn_fin         = (state == ST_DWAIT) && dn_rsp_valid;

  scom_addr_filter #(.RAW(RAW)) u_filter (
    .reg_addr (reg_addr),
    .is_write (mmio_req_write),
    .act      (act)
  );

  assign set_done = (acc && shape_ok && !in_status && (act != ACT_FWD)) || dn_fin;
  assign set_fail = dn_fin && dn_rsp_err;
  assign clr_en   = acc && shape_ok && in_status && mmio_req_write;

  scom_cpl_status u_status (
    .clk      (clk),
    .rst      (rst),
    .set_done (set_done),
    .set_fail (set_fail),
    .clr_en   (clr_en),
    .clr_mask (mmio_req_wdata[1:0]),
    .done     (st_done),
    .fail     (st_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      mmio_rsp_valid <= 1'b0;
      mmio_rsp_err   <= 1'b0;
      mmio_rsp_rdata <= '0;
      dn_req_valid   <= 1'b0;
      dn_req_write   <= 1'b0;
      dn_req_addr    <= '0;
      dn_req_wdata   <= '0;
    end else begin
      mmio_rsp_valid <= 1'b0;
      mmio_rsp_err   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (acc) begin
            if (!shape_ok) begin
              mmio_rsp_valid <= 1'b1;
              mmio_rsp_err   <= 1'b1;
              mmio_rsp_rdata <= '0;
            end else if (in_status) begin
              mmio_rsp_valid <= 1'b1;
              mmio_rsp_rdata <= mmio_req_write ? '0 : DW'({st_fail, st_done});
            end else begin
              case (act)
                ACT_ID: begin
                  mmio_rsp_valid <= 1'b1;
                  mmio_rsp_rdata <= lane_swap(CHIP_ID);
                end
                ACT_ZERO, ACT_DROP: begin
                  mmio_rsp_valid <= 1'b1;
                  mmio_rsp_rdata <= '0;
                end
                default: begin
                  dn_req_valid <= 1'b1;
                  dn_req_write <= mmio_req_write;
                  dn_req_addr  <= {reg_addr, 3'b000};
                  dn_req_wdata <= lane_swap(mmio_req_wdata);
                  state        <= ST_DREQ;
                end
              endcase
            end
          end
        end
        ST_DREQ: begin
          if (dn_req_ready) begin
            dn_req_valid <= 1'b0;
            state        <= ST_DWAIT;
          end
        end
        ST_DWAIT: begin
          if (dn_rsp_valid) begin
            mmio_rsp_valid <= 1'b1;
            mmio_rsp_rdata <= (dn_rsp_err || dn_req_write) ? '0 : lane_swap(dn_rsp_rdata);
            state          <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scom_bridge_chk.sv
module scom_bridge_chk #(
  parameter int RAW = 32,
  parameter int DW  = 64
) (
  input logic           clk,
  input logic           rst,
  input logic           mmio_req_valid,
  input logic           mmio_req_ready,
  input logic           mmio_req_write,
  input logic [RAW+3:0] mmio_req_addr,
  input logic [3:0]     mmio_req_size,
  input logic [DW-1:0]  mmio_req_wdata,
  input logic           mmio_rsp_valid,
  input logic           mmio_rsp_err,
  input logic [DW-1:0]  mmio_rsp_rdata,
  input logic           dn_req_valid,
  input logic           dn_req_ready,
  input logic           dn_req_write,
  input logic [RAW+2:0] dn_req_addr,
  input logic [DW-1:0]  dn_req_wdata,
  input logic           dn_rsp_valid,
  input logic           dn_rsp_err,
  input logic           st_done,
  input logic           st_fail
);

  logic acc_c;
  logic good_shape_c;
  logic stat_wr_c;

  assign acc_c        = mmio_req_valid && mmio_req_ready;
  assign good_shape_c = (mmio_req_size == 4'd8) && (mmio_req_addr[2:0] == 3'b000);
  assign stat_wr_c    = acc_c && good_shape_c && mmio_req_write && mmio_req_addr[RAW+3];

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr) &&
                                      $stable(dn_req_wdata) && $stable(dn_req_write));

  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> !mmio_req_ready);

  p_one_path_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mmio_rsp_valid, dn_req_valid}));

  p_reject_r1: assert property (@(posedge clk) disable iff (rst)
    acc_c && !good_shape_c |=> mmio_rsp_valid && mmio_rsp_err && !dn_req_valid &&
                               (mmio_rsp_rdata == '0) && $stable(st_done) && $stable(st_fail));

  p_dn_err_r10: assert property (@(posedge clk) disable iff (rst)
    dn_rsp_valid && dn_rsp_err && !mmio_req_ready && !dn_req_valid
      |=> st_fail && st_done && mmio_rsp_valid && (mmio_rsp_rdata == '0));

  p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
    st_done && !(stat_wr_c && mmio_req_wdata[0]) |=> st_done);

  p_fail_hold_r11: assert property (@(posedge clk) disable iff (rst)
    st_fail && !(stat_wr_c && mmio_req_wdata[1]) |=> st_fail);

endmodule

bind scom_bridge scom_bridge_chk #(.RAW(RAW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mmio_req_valid (mmio_req_valid),
  .mmio_req_ready (mmio_req_ready),
  .mmio_req_write (mmio_req_write),
  .mmio_req_addr  (mmio_req_addr),
  .mmio_req_size  (mmio_req_size),
  .mmio_req_wdata (mmio_req_wdata),
  .mmio_rsp_valid (mmio_rsp_valid),
  .mmio_rsp_err   (mmio_rsp_err),
  .mmio_rsp_rdata (mmio_rsp_rdata),
  .dn_req_valid   (dn_req_valid),
  .dn_req_ready   (dn_req_ready),
  .dn_req_write   (dn_req_write),
  .dn_req_addr    (dn_req_addr),
  .dn_req_wdata   (dn_req_wdata),
  .dn_rsp_valid   (dn_rsp_valid),
  .dn_rsp_err     (dn_rsp_err),
  .st_done        (st_done),
  .st_fail        (st_fail)
);

// File: tb/sim_scom_bridge.sv
module sim_scom_bridge;

  localparam int          CLK_P = 10;
  localparam logic [63:0] CID   = 64'h1122_3344_5566_7788;
  localparam logic [35:0] STAT  = 36'h8_0000_0000;
  localparam int          NV    = 17;
  // {write, kind, register}; kind 0 forward, 1 zero, 2 identity, 3 dropped
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 2'd2, 32'h000f_000f},
    {1'b1, 2'd3, 32'h000f_000f},
    {1'b0, 2'd1, 32'h0001_8002},
    {1'b0, 2'd1, 32'h0101_0c03},
    {1'b0, 2'd1, 32'h000f_0034},
    {1'b0, 2'd1, 32'h0202_000f},
    {1'b1, 2'd3, 32'h0101_0c04},
    {1'b1, 2'd3, 32'h0102_0013},
    {1'b1, 2'd3, 32'h0009_0012},
    {1'b0, 2'd1, 32'h0201_3f05},
    {1'b1, 2'd0, 32'h0201_3f01},
    {1'b0, 2'd0, 32'h0101_0c01},
    {1'b0, 2'd0, 32'h1234_5678},
    {1'b1, 2'd0, 32'hffff_ffff},
    {1'b0, 2'd0, 32'h0bad_0000},
    {1'b1, 2'd0, 32'h0bad_0000},
    {1'b0, 2'd0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        mmio_req_valid, mmio_req_ready, mmio_req_write;
  logic [35:0] mmio_req_addr;
  logic [3:0]  mmio_req_size;
  logic [63:0] mmio_req_wdata;
  logic        mmio_rsp_valid, mmio_rsp_err;
  logic [63:0] mmio_rsp_rdata;
  logic        dn_req_valid, dn_req_ready, dn_req_write;
  logic [34:0] dn_req_addr;
  logic [63:0] dn_req_wdata;
  logic        dn_rsp_valid, dn_rsp_err;
  logic [63:0] dn_rsp_rdata;

  int          total = 0;
  int          bad   = 0;
  int          seen  = 0;
  bit          fin   = 1'b0;
  logic [34:0] last_addr;
  logic [63:0] last_wd;
  logic        last_wr;

  always #(CLK_P/2) clk = ~clk;

  scom_bridge #(.CHIP_ID(CID)) u0 (
    .clk(clk), .rst(rst),
    .mmio_req_valid(mmio_req_valid), .mmio_req_ready(mmio_req_ready),
    .mmio_req_write(mmio_req_write), .mmio_req_addr(mmio_req_addr),
    .mmio_req_size(mmio_req_size), .mmio_req_wdata(mmio_req_wdata),
    .mmio_rsp_valid(mmio_rsp_valid), .mmio_rsp_err(mmio_rsp_err),
    .mmio_rsp_rdata(mmio_rsp_rdata),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_write(dn_req_write), .dn_req_addr(dn_req_addr),
    .dn_req_wdata(dn_req_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata)
  );

  function automatic logic [63:0] flip(input logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[63-8*i -: 8];
    return r;
  endfunction

  function automatic logic [63:0] model_rd(input logic [31:0] r);
    return {~r, r};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_acc(input logic wr, input logic [35:0] off, input logic [63:0] wd,
                        input logic [3:0] sz, output logic [63:0] rd, output logic er,
                        output int lat, output bit ready_ok);
    bit took;
    ready_ok = 1'b1;
    @(negedge clk);
    mmio_req_valid = 1'b1; mmio_req_write = wr; mmio_req_addr = off;
    mmio_req_size = sz; mmio_req_wdata = wd;
    do begin
      took = mmio_req_ready;
      @(posedge clk);
    end while (!took);
    @(negedge clk);
    mmio_req_valid = 1'b0;
    lat = 1;
    while (!mmio_rsp_valid && lat < 60) begin
      if (mmio_req_ready) ready_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    rd = mmio_rsp_rdata;
    er = mmio_rsp_err;
  endtask

  // downstream model: stalls one cycle, then accepts, then answers
  initial begin
    logic [34:0] a;
    dn_req_ready = 1'b0; dn_rsp_valid = 1'b0; dn_rsp_err = 1'b0; dn_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (dn_req_valid && !rst) begin
        seen++;
        a = dn_req_addr; last_addr = dn_req_addr;
        last_wd = dn_req_wdata; last_wr = dn_req_write;
        @(negedge clk);
        chk(dn_req_valid && dn_req_addr == a, "R8 request held", 64'(dn_req_addr), 64'(a));
        dn_req_ready = 1'b1;
        @(negedge clk);
        dn_req_ready = 1'b0;
        @(negedge clk);
        dn_rsp_valid = 1'b1;
        dn_rsp_err   = (a[34:3] == 32'h0bad_0000);
        dn_rsp_rdata = model_rd(a[34:3]);
        @(negedge clk);
        dn_rsp_valid = 1'b0; dn_rsp_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, wd, exp;
    logic        er, wr;
    logic [1:0]  kind;
    logic [31:0] ra;
    int          lat, s0;
    bit          rok;
    rst = 1'b1; mmio_req_valid = 1'b0; mmio_req_write = 1'b0;
    mmio_req_addr = '0; mmio_req_size = 4'd8; mmio_req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mmio_req_ready && !mmio_rsp_valid && !dn_req_valid, "R12 reset state",
        {61'b0, mmio_req_ready, mmio_rsp_valid, dn_req_valid}, 64'h4);
    rst = 1'b0;
    do_acc(1'b0, STAT, '0, 4'd8, rd, er, lat, rok);
    chk(rd == 64'h0, "R11 status after reset", rd, 64'h0);
    chk(lat == 1, "R12 status latency", 64'(lat), 64'd1);

    for (int i = 0; i < NV; i++) begin
      {wr, kind, ra} = VEC[i];
      wd = 64'h0123_4567_89ab_cdef + 64'(i);
      s0 = seen;
      do_acc(wr, {1'b0, ra, 3'b000}, wd, 4'd8, rd, er, lat, rok);
      repeat (2) @(negedge clk);
      chk(!er, "R1 valid access not rejected", 64'(er), 64'h0);
      if (kind == 2'd0) begin
        chk(seen == s0 + 1, "R2 forwarded once", 64'(seen - s0), 64'd1);
        chk(last_addr == {ra, 3'b000}, "R2 byte address", 64'(last_addr), 64'({ra, 3'b000}));
        chk(last_wr == wr, "R6 write flag", 64'(last_wr), 64'(wr));
        chk(rok, "R8 ready low while pending", 64'(rok), 64'd1);
        if (wr) begin
          chk(last_wd == flip(wd), "R7 write lanes", last_wd, flip(wd));
          chk(rd == 64'h0, "R7 write response zero", rd, 64'h0);
        end else begin
          exp = (ra == 32'h0bad_0000) ? 64'h0 : flip(model_rd(ra));
          chk(rd == exp, "R10 forwarded read data", rd, exp);
        end
      end else begin
        chk(seen == s0, "R5 no downstream for local", 64'(seen - s0), 64'd0);
        chk(lat == 1, "R12 local latency", 64'(lat), 64'd1);
        exp = (kind == 2'd2) ? flip(CID) : 64'h0;
        chk(rd == exp, (kind == 2'd2) ? "R3 identity read" : "R4 local read value", rd, exp);
      end
    end

    do_acc(1'b0, STAT, '0, 4'd8, rd, er, lat, rok);
    chk(rd == 64'h3, "R9 R10 accumulated flags", rd, 64'h3);
    do_acc(1'b1, STAT, 64'h1, 4'd8, rd, er, lat, rok);
    do_acc(1'b0, STAT, '0, 4'd8, rd, er, lat, rok);
    chk(rd == 64'h2, "R11 clear done only", rd, 64'h2);
    do_acc(1'b1, STAT, 64'h2, 4'd8, rd, er, lat, rok);
    do_acc(1'b0, STAT, '0, 4'd8, rd, er, lat, rok);
    chk(rd == 64'h0, "R11 clear fail", rd, 64'h0);

    s0 = seen;
    do_acc(1'b0, {1'b0, 32'h1234_5678, 3'b100}, '0, 4'd8, rd, er, lat, rok);
    repeat (2) @(negedge clk);
    chk(er && rd == 64'h0 && lat == 1, "R1 misaligned rejected", {rd[62:0], er}, 64'h1);
    do_acc(1'b1, {1'b0, 32'h1234_5678, 3'b000}, 64'hff, 4'd4, rd, er, lat, rok);
    repeat (2) @(negedge clk);
    chk(er, "R1 short size rejected", 64'(er), 64'h1);
    chk(seen == s0, "R1 no downstream on reject", 64'(seen - s0), 64'd0);
    do_acc(1'b0, STAT, '0, 4'd8, rd, er, lat, rok);
    chk(rd == 64'h0, "R1 flags untouched by reject", rd, 64'h0);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule